// File: doc/BRIEF.md
# Serial Port Hold Qualifier with Frozen Receive Shifter

This block sits behind the input synchronizers of a serial memory slave port. It watches the hold request, the serial clock and the chip select, and decides when the port is paused. While the port is paused, the receive shifter and its bit counter are frozen and the serial output driver is told to float. A transfer that is paused in the middle of a word carries on at the same bit once the pause ends. Pause entry and pause exit are not taken directly from the edges of the hold request. Each one waits until the serial clock is seen in its low level.

If chip select is released while the port is paused, the block issues a single-cycle reset to the serial front end. The pause indication then stays asserted for as long as the hold request stays low. After that, traffic is only accepted again once the hold request has gone high and chip select has gone high and then low again. All inputs are already synchronous to `clk`. Serial clock rising edges are detected in the `clk` domain, so both idle polarities of the serial clock work the same way.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_active_o`, `so_oe_block_o`, `frontend_reset_o` and `rx_valid_o` are 0 and `bit_pos_o` is 0.
- R2: When `hold_n_i`, `sck_i` and `cs_n_i` are all sampled low at a rising edge of `clk`, `hold_active_o` is 1 after that edge.
- R3: While `sck_i` is sampled high, a low `hold_n_i` does not start a pause. The pause begins at the first edge where `sck_i` is sampled low with `hold_n_i` still low. If `hold_n_i` returns high before that edge, no pause occurs.
- R4: No pause starts while `cs_n_i` is high.
- R5: A pause with chip select low ends at the first edge where `hold_n_i` is high and `sck_i` is low. While `sck_i` stays high, the pause continues even though `hold_n_i` is high.
- R6: While `so_oe_block_o` is 1, rising edges of `sck_i` and the values on `si_i` have no effect: `bit_pos_o` keeps its value and `rx_valid_o` stays 0. After the pause ends, the word resumes at the same bit position.
- R7: `so_oe_block_o` is 1 whenever `hold_active_o` is 1.
- R8: If `cs_n_i` is sampled high during a pause, `frontend_reset_o` is 1 for exactly one `clk` cycle and `bit_pos_o` returns to 0. `hold_active_o` stays 1 for as long as `hold_n_i` stays low.
- R9: After such a deselect, raising `hold_n_i` clears `hold_active_o`. If `cs_n_i` is low at that moment, `so_oe_block_o` stays 1 and serial clock edges are ignored until `cs_n_i` is sampled high.
- R10: With no pause, each rising edge of `sck_i` shifts in `si_i` MSB first and advances `bit_pos_o`. After `WORD_W` edges, `rx_word_o` holds the word and `rx_valid_o` pulses for one cycle. `cs_n_i` high clears `bit_pos_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n_i | input | 1 | Synchronized hold request, active low |
| sck_i | input | 1 | Synchronized serial clock level |
| cs_n_i | input | 1 | Synchronized chip select, active low |
| si_i | input | 1 | Synchronized serial data in |
| hold_active_o | output | 1 | Pause qualifier for the front end |
| so_oe_block_o | output | 1 | Forces the serial output driver to high impedance |
| frontend_reset_o | output | 1 | One-cycle reset of the serial front end |
| bit_pos_o | output | POS_W | Bit position within the current word |
| rx_word_o | output | WORD_W | Last complete received word |
| rx_valid_o | output | 1 | One-cycle strobe when a word completes |

## Verification
The hardest case to reach from the ports is the lockout path. It needs four steps in order: a pause started in the middle of a word, then chip select released during the pause, then chip select asserted again while the hold request is still low, and only then the hold request released. A directed sequence walks through exactly these steps and checks three things along the way: the single reset pulse, that serial clock edges are ignored during the lockout, and that a fresh word is received after reselection. Long constrained-random runs toggle the serial clock, hold request and chip select at different rates. A bench model built from the requirements checks every cycle of these runs, which covers the deferred entry and exit cases and the pauses that begin or end near a word boundary.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   // Pause controller states
   typedef enum logic [1:0] {
      HS_RUN   = 2'd0,   // normal traffic
      HS_HOLD  = 2'd1,   // paused, chip select still low
      HS_DESEL = 2'd2,   // paused, front end already reset by deselect
      HS_LOCK  = 2'd3    // released after deselect, waiting for chip select high
   } hold_st_e;

endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   if (N < 1) begin : g_bad_n
      $error("spi_hold_edge: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~prev_q;
      assign fall_o[g] = ~lvl_i[g] & prev_q;
   end

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n_i,
   input  logic sck_i,
   input  logic cs_n_i,
   output logic hold_active_o,
   output logic so_oe_block_o,
   output logic freeze_o,
   output logic fe_reset_o
);

   hold_st_e st_q, st_d;
   logic     rst_d;
   logic     hold_q, block_q, fe_rst_q;

   always_comb begin
      st_d  = st_q;
      rst_d = 1'b0;
      unique case (st_q)
         HS_RUN: begin
            if (!cs_n_i && !hold_n_i && !sck_i) st_d = HS_HOLD;
         end
         HS_HOLD: begin
            if (cs_n_i) begin
               st_d  = HS_DESEL;
               rst_d = 1'b1;
            end else if (hold_n_i && !sck_i) begin
               st_d = HS_RUN;
            end
         end
         HS_DESEL: begin
            if (hold_n_i) st_d = cs_n_i ? HS_RUN : HS_LOCK;
         end
         HS_LOCK: begin
            if (cs_n_i) st_d = HS_RUN;
         end
         default: st_d = HS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= HS_RUN;
         hold_q   <= 1'b0;
         block_q  <= 1'b0;
         fe_rst_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         hold_q   <= (st_d == HS_HOLD) || (st_d == HS_DESEL);
         block_q  <= (st_d != HS_RUN);
         fe_rst_q <= rst_d;
      end
   end

   assign hold_active_o = hold_q;
   assign so_oe_block_o = block_q;
   assign freeze_o      = block_q;
   assign fe_reset_o    = fe_rst_q;

   // R3: a high serial clock defers entry
   p_entry_waits_low_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_RUN && sck_i) |=> !hold_active_o);

   // R4: no entry while deselected
   p_no_entry_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_RUN && cs_n_i) |=> !hold_active_o);

   // R5: a high serial clock defers exit
   p_exit_waits_low_sck_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_HOLD && !cs_n_i && sck_i) |=> hold_active_o);

   // R7: output blocking covers every paused cycle
   p_block_covers_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> so_oe_block_o);

   // R8: front-end reset lasts one cycle
   p_reset_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fe_reset_o |=> !fe_reset_o);

   // R8: deselected pause persists while the request stays low
   p_desel_persists_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_DESEL && !hold_n_i) |=> hold_active_o);

endmodule

// File: rtl/spi_hold_shift.sv
module spi_hold_shift #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int POS_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise_i,
   input  logic              si_i,
   input  logic              freeze_i,
   input  logic              clear_i,
   output logic [POS_W-1:0]  bit_pos_o,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

   if (WORD_W < 2) begin : g_bad_w
      $error("spi_hold_shift: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] sh_q, sh_nx;
   logic [POS_W-1:0]  pos_q;
   logic [WORD_W-1:0] word_q;
   logic              vld_q;
   logic              take;

   if (MSB_FIRST) begin : g_msb
      assign sh_nx = {sh_q[WORD_W-2:0], si_i};
   end else begin : g_lsb
      assign sh_nx = {si_i, sh_q[WORD_W-1:1]};
   end

   assign take = sck_rise_i && !freeze_i && !clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         pos_q  <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (clear_i) begin
            sh_q  <= '0;
            pos_q <= '0;
         end else if (take) begin
            sh_q <= sh_nx;
            if (pos_q == LAST_POS) begin
               pos_q  <= '0;
               word_q <= sh_nx;
               vld_q  <= 1'b1;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   assign bit_pos_o  = pos_q;
   assign word_o     = word_q;
   assign word_vld_o = vld_q;

   // R6: a frozen shifter keeps its position
   p_frozen_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_i && !clear_i) |=> $stable(bit_pos_o));

   // R6: no word completes while frozen
   p_frozen_no_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_i |=> !word_vld_o);

   // R10: completion strobe is a single cycle
   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int POS_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_n_i,
   input  logic              sck_i,
   input  logic              cs_n_i,
   input  logic              si_i,
   output logic              hold_active_o,
   output logic              so_oe_block_o,
   output logic              frontend_reset_o,
   output logic [POS_W-1:0]  bit_pos_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              rx_valid_o
);

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_hold_ctrl: WORD_W must be at least 2");
   end

   logic [0:0] sck_rise, sck_fall;
   logic       freeze;
   logic       fe_reset;
   logic       clear;

   spi_hold_edge #(.N(1)) i_sck_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sck_i),
      .rise_o (sck_rise),
      .fall_o (sck_fall)
   );

   spi_hold_fsm i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .hold_n_i      (hold_n_i),
      .sck_i         (sck_i),
      .cs_n_i        (cs_n_i),
      .hold_active_o (hold_active_o),
      .so_oe_block_o (so_oe_block_o),
      .freeze_o      (freeze),
      .fe_reset_o    (fe_reset)
   );

   assign clear            = cs_n_i | fe_reset;
   assign frontend_reset_o = fe_reset;

   spi_hold_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_rise_i (sck_rise[0]),
      .si_i       (si_i),
      .freeze_i   (freeze),
      .clear_i    (clear),
      .bit_pos_o  (bit_pos_o),
      .word_o     (rx_word_o),
      .word_vld_o (rx_valid_o)
   );

   // R9: lockout keeps the output blocked while chip select stays low
   p_lockout_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe_block_o && !hold_active_o && !cs_n_i) |=> so_oe_block_o);

   // R8: reset pulse only appears inside a pause
   p_reset_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frontend_reset_o |-> hold_active_o);

   logic unused_fall;
   assign unused_fall = sck_fall[0];

endmodule

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;

   localparam int W  = 8;
   localparam int PW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_n = 1'b1, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
   logic hold_active, so_block, fe_rst, rx_valid;
   logic [PW-1:0] bit_pos;
   logic [W-1:0]  rx_word;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_hold_ctrl #(.WORD_W(W), .MSB_FIRST(1'b1)) i_spi_hold_ctrl (
      .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n), .sck_i(sck), .cs_n_i(cs_n),
      .si_i(si), .hold_active_o(hold_active), .so_oe_block_o(so_block),
      .frontend_reset_o(fe_rst), .bit_pos_o(bit_pos), .rx_word_o(rx_word),
      .rx_valid_o(rx_valid)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // one serial bit: low phase, then high phase (rising edge shifts)
   task automatic sbit(input logic d);
      si = d; sck = 1'b0; tick();
      sck = 1'b1; tick();
   endtask

   // ---------------- bench reference model ----------------
   int          m_st;      // 0 run, 1 paused, 2 paused after deselect, 3 lockout
   logic        m_prev, m_rst, m_vld;
   int          m_pos;
   logic [W-1:0] m_sh, m_word;

   function automatic void model_reset();
      m_st = 0; m_prev = 1'b0; m_rst = 1'b0; m_vld = 1'b0;
      m_pos = 0; m_sh = '0; m_word = '0;
   endfunction

   function automatic void model_step(input logic h, input logic s, input logic c, input logic d);
      int   ns = m_st;
      logic nr = 1'b0;
      logic frz = (m_st != 0);
      logic clr = c | m_rst;
      logic rise = s & ~m_prev;
      case (m_st)
         0: if (!c && !h && !s) ns = 1;
         1: if (c) begin ns = 2; nr = 1'b1; end else if (h && !s) ns = 0;
         2: if (h) ns = c ? 0 : 3;
         default: if (c) ns = 0;
      endcase
      m_vld = 1'b0;
      if (clr) begin
         m_pos = 0; m_sh = '0;
      end else if (rise && !frz) begin
         m_sh = {m_sh[W-2:0], d};
         if (m_pos == W-1) begin m_pos = 0; m_word = m_sh; m_vld = 1'b1; end
         else m_pos++;
      end
      m_prev = s;
      m_st = ns;
      m_rst = nr;
   endfunction

   function automatic int exp_hold();  return (m_st == 1 || m_st == 2) ? 1 : 0; endfunction
   function automatic int exp_block(); return (m_st != 0) ? 1 : 0; endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [W-1:0] b;
      void'($urandom(32'd1357));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1", "hold_active", hold_active, 0);
      chk("R1", "so_block", so_block, 0);
      chk("R1", "fe_reset", fe_rst, 0);
      chk("R1", "rx_valid", rx_valid, 0);
      chk("R1", "bit_pos", bit_pos, 0);

      // R10 plain word, MSB first
      cs_n = 1'b0; tick();
      b = 8'hA5;
      for (int i = W-1; i >= 0; i--) begin
         sbit(b[i]);
         if (i != 0) chk("R10", "bit_pos", bit_pos, W-i);
      end
      chk("R10", "rx_valid", rx_valid, 1);
      chk("R10", "rx_word", rx_word, 8'hA5);
      sck = 1'b0; tick();
      chk("R10", "rx_valid pulse end", rx_valid, 0);

      // R2 / R6 / R5 pause mid-word
      b = 8'h3C;
      for (int i = W-1; i >= 4; i--) sbit(b[i]);
      chk("R10", "bit_pos before pause", bit_pos, 4);
      sck = 1'b0; hold_n = 1'b0; tick();
      chk("R2", "hold entry with low sck", hold_active, 1);
      chk("R7", "so_block during pause", so_block, 1);
      for (int k = 0; k < 3; k++) begin
         sbit(1'b1);
         chk("R6", "bit_pos frozen", bit_pos, 4);
         chk("R6", "no rx_valid while frozen", rx_valid, 0);
      end
      hold_n = 1'b1; tick();                 // sck still high
      chk("R5", "exit deferred while sck high", hold_active, 1);
      sck = 1'b0; tick();
      chk("R5", "exit at low sck", hold_active, 0);
      chk("R7", "so_block released", so_block, 0);
      for (int i = 3; i >= 0; i--) sbit(b[i]);
      chk("R6", "resumed word valid", rx_valid, 1);
      chk("R6", "resumed word value", rx_word, 8'h3C);
      sck = 1'b0; tick();

      // R3 deferred entry
      sck = 1'b1; hold_n = 1'b0; tick();
      chk("R3", "no entry while sck high", hold_active, 0);
      tick();
      chk("R3", "still no entry", hold_active, 0);
      sck = 1'b0; tick();
      chk("R3", "entry at next low sck", hold_active, 1);
      hold_n = 1'b1; tick();
      chk("R5", "immediate exit with low sck", hold_active, 0);
      cs_n = 1'b1; tick();
      chk("R10", "cs high clears bit_pos", bit_pos, 0);

      // R3 short request while sck high
      cs_n = 1'b0; tick();
      sck = 1'b1; tick();
      hold_n = 1'b0; tick();
      hold_n = 1'b1; tick();
      sck = 1'b0; tick();
      chk("R3", "withdrawn request gives no pause", hold_active, 0);
      cs_n = 1'b1; tick();

      // R4 deselected
      sck = 1'b0; hold_n = 1'b0; tick();
      chk("R4", "no pause while deselected", hold_active, 0);
      chk("R4", "no block while deselected", so_block, 0);
      hold_n = 1'b1; tick();

      // R8 / R9 deselect during pause, then lockout
      cs_n = 1'b0; tick();
      sbit(1'b1); sbit(1'b0); sbit(1'b1);
      chk("R10", "bit_pos 3", bit_pos, 3);
      sck = 1'b0; hold_n = 1'b0; tick();
      chk("R2", "paused", hold_active, 1);
      cs_n = 1'b1; tick();
      chk("R8", "reset pulse", fe_rst, 1);
      chk("R8", "still paused", hold_active, 1);
      chk("R8", "bit_pos cleared", bit_pos, 0);
      tick();
      chk("R8", "reset single cycle", fe_rst, 0);
      repeat (4) tick();
      chk("R8", "pause held while request low", hold_active, 1);
      cs_n = 1'b0; tick();
      chk("R8", "pause held after reselect", hold_active, 1);
      hold_n = 1'b1; tick();
      chk("R9", "pause cleared", hold_active, 0);
      chk("R9", "output still blocked", so_block, 1);
      for (int k = 0; k < 3; k++) sbit(1'b1);
      chk("R9", "edges ignored in lockout", bit_pos, 0);
      chk("R9", "no word in lockout", rx_valid, 0);
      sck = 1'b0; cs_n = 1'b1; tick();
      chk("R9", "lockout ends on cs high", so_block, 0);
      cs_n = 1'b0; tick();
      b = 8'h5A;
      for (int i = W-1; i >= 0; i--) sbit(b[i]);
      chk("R9", "word after reselect valid", rx_valid, 1);
      chk("R9", "word after reselect value", rx_word, 8'h5A);
      sck = 1'b0; cs_n = 1'b1; tick();

      // constrained random against the bench model
      rst_n = 1'b0; hold_n = 1'b1; sck = 1'b0; cs_n = 1'b1; si = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      model_reset();
      tick();
      for (int n = 0; n < 6000; n++) begin
         if ($urandom_range(1, 0) == 1) sck = ~sck;
         if ($urandom_range(7, 0) == 0) hold_n = ~hold_n;
         if ($urandom_range(24, 0) == 0) cs_n = ~cs_n;
         si = 1'($urandom_range(1, 0));
         model_step(hold_n, sck, cs_n, si);
         tick();
         chk("R2", "rand hold_active", hold_active, exp_hold());
         chk("R7", "rand so_block", so_block, exp_block());
         chk("R8", "rand fe_reset", fe_rst, m_rst);
         chk("R6", "rand bit_pos", bit_pos, m_pos);
         chk("R10", "rand rx_valid", rx_valid, m_vld);
         chk("R10", "rand rx_word", rx_word, m_word);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule